// File: doc/BRIEF.md
# Chirp Waveform Sequencer

This block decides which of three chirp waveforms (short, medium, long) the radar sends next and when it sends it. It drives a 2-bit waveform code and a one-cycle chirp-start strobe to the matched filter and clutter canceller further down the receive chain. Everything runs in one clock domain. The chirp repetition interval, the number of chirps in a sub-frame and the watchdog's idle-frame limit are parameters.

A 2-bit mode input picks one of four behaviours:

- **Pass-through (00):** an external request decides chirp timing.
- **Scan (01):** the block rotates through short, medium and long sub-frames. A runtime enable mask can drop any waveform from the rotation.
- **Debug (10):** the block fires a single chirp.
- **Track dwell (11):** the block chirps repeatedly on a configured waveform. An idle-frame watchdog falls back to scanning when no track activity is seen, and activity during the fallback brings it back to dwell.

The FSM states are as follows:

- `ST_PASS`: pass-through.
- `ST_SCAN`: scan.
- `ST_DBG_FIRE`: debug, the one chirp.
- `ST_DBG_HOLD`: debug, silent after the chirp.
- `ST_DWELL`: track dwell.
- `ST_FALLBACK`: scanning under track mode.

The transitions are as follows:

- Any state moves to the entry state of a new mode (`ST_PASS`, `ST_SCAN`, `ST_DBG_FIRE` or `ST_DWELL`) whenever `mode_sel` differs from the current state's mode.
- `ST_DBG_FIRE` moves to `ST_DBG_HOLD` after one cycle.
- `ST_DWELL` moves to `ST_FALLBACK` when the watchdog expires.
- `ST_FALLBACK` moves to `ST_DWELL` at the end of a chirp slot once track activity has been seen.

Both outputs are registered, so each leaves the block one cycle after the state that produces it.

Top module: `chirp_sequencer`

## Requirements
- R1: During reset and in the first cycle after it, chirp_pulse is 0 and wave_sel is 00. The block starts in pass-through. From the next cycle on, wave_sel follows fixed_wave.
- R2: chirp_pulse is high for exactly one cycle per chirp. In scan, dwell and fallback, chirps come every PRI_CYCLES cycles.
- R3: In pass-through (mode 00), each rising edge of ext_req gives exactly one chirp_pulse, however long ext_req stays high. wave_sel equals fixed_wave.
- R4: Scan (mode 01) issues CHIRPS_PER_SUB chirps on each waveform in the order SHORT=00, MEDIUM=01, LONG=10, then wraps. wave_sel changes only in a cycle that carries chirp_pulse.
- R5: wave_mask bit i enables waveform code i. A disabled waveform is skipped with no empty slot, so spacing stays PRI_CYCLES. With wave_mask=000, scan emits no chirp_pulse.
- R6: Entering debug (mode 10) gives exactly one chirp_pulse on fixed_wave. No further chirps follow until the mode is left and entered again.
- R7: Track dwell (mode 11) chirps periodically on fixed_wave. A frame is CHIRPS_PER_SUB chirps.
- R8: After IDLE_FRAMES consecutive dwell frames with no track_hit, the block falls back to scan. It starts at the first enabled waveform in the slot right after the last dwell chirp slot, with spacing kept.
- R9: A track_hit in any cycle of a frame, including its last cycle, restarts the idle-frame count.
- R10: A track_hit during fallback returns the block to dwell at the next chirp-slot boundary, with spacing kept.
- R11: A change of mode_sel takes effect at the next clock edge. Periodic modes show their first chirp_pulse two cycles after the new mode_sel is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 pass-through, 01 scan, 10 debug, 11 track dwell |
| ext_req | input | 1 | External chirp request used in pass-through |
| wave_mask | input | 3 | Per-waveform enable for scan rotation, bit i enables code i |
| fixed_wave | input | 2 | Waveform code for pass-through, debug and dwell |
| track_hit | input | 1 | Track activity indication |
| wave_sel | output | 2 | Waveform code of the current chirp |
| chirp_pulse | output | 1 | One-cycle chirp start strobe |

## Verification
The watchdog's end-of-frame decision and a track-activity assertion can land in the same cycle: the final cycle of the fifth consecutive idle frame. The bench counts dwell chirps to find that exact cycle and raises track_hit there alone. The design passes if dwell continues for five further frames, giving twenty dwell chirps in all, before the fallback chirp on SHORT appears. A return request in fallback that arrives mid-slot is judged separately: the spacing to the next dwell chirp must stay one full interval.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

    localparam logic [1:0] WAVE_SHORT  = 2'b00;
    localparam logic [1:0] WAVE_MEDIUM = 2'b01;
    localparam logic [1:0] WAVE_LONG   = 2'b10;

    localparam logic [1:0] MODE_PASS  = 2'b00;
    localparam logic [1:0] MODE_SCAN  = 2'b01;
    localparam logic [1:0] MODE_DEBUG = 2'b10;
    localparam logic [1:0] MODE_TRACK = 2'b11;

    typedef enum logic [2:0] {
        ST_PASS,
        ST_SCAN,
        ST_DBG_FIRE,
        ST_DBG_HOLD,
        ST_DWELL,
        ST_FALLBACK
    } seq_state_e;

    // rotation successor: short -> medium -> long -> short
    function automatic logic [1:0] wave_succ(input logic [1:0] w);
        case (w)
            WAVE_SHORT:  wave_succ = WAVE_MEDIUM;
            WAVE_MEDIUM: wave_succ = WAVE_LONG;
            default:     wave_succ = WAVE_SHORT;
        endcase
    endfunction

endpackage

// File: rtl/chirp_seq_slot_timer.sv
module chirp_seq_slot_timer #(
    parameter int PRI_CYCLES     = 1000,
    parameter int CHIRPS_PER_SUB = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic slot_start,
    output logic slot_last,
    output logic chirp_first,
    output logic frame_end
);
    localparam int SLOT_W = $clog2(PRI_CYCLES);
    localparam int IDX_W  = (CHIRPS_PER_SUB > 1) ? $clog2(CHIRPS_PER_SUB) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST_V = SLOT_W'(PRI_CYCLES - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST_V  = IDX_W'(CHIRPS_PER_SUB - 1);

    logic [SLOT_W-1:0] slot_cnt;
    logic [IDX_W-1:0]  chirp_idx;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot_cnt  <= '0;
            chirp_idx <= '0;
        end else if (run) begin
            if (slot_cnt == SLOT_LAST_V) begin
                slot_cnt  <= '0;
                chirp_idx <= (chirp_idx == IDX_LAST_V) ? '0 : chirp_idx + 1'b1;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    assign slot_start  = (slot_cnt == '0);
    assign slot_last   = (slot_cnt == SLOT_LAST_V);
    assign chirp_first = (chirp_idx == '0);
    assign frame_end   = slot_last && (chirp_idx == IDX_LAST_V);

    // R2: slot counter never leaves its interval
    a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt <= SLOT_LAST_V) && (chirp_idx <= IDX_LAST_V));

endmodule

// File: rtl/chirp_seq_wave_rotor.sv
module chirp_seq_wave_rotor
    import chirp_seq_pkg::*;
(
    input  logic [1:0] from_wave,
    input  logic [2:0] wave_mask,
    output logic [1:0] next_wave
);
    always_comb begin
        logic [1:0] cand;
        logic       found;
        next_wave = from_wave;
        cand      = from_wave;
        found     = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cand = wave_succ(cand);
            if (!found && wave_mask[cand]) begin
                next_wave = cand;
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/chirp_seq_idle_watchdog.sv
module chirp_seq_idle_watchdog #(
    parameter int IDLE_FRAMES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic frame_end,
    input  logic hit,
    output logic expire
);
    localparam int CNT_W = $clog2(IDLE_FRAMES + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(IDLE_FRAMES - 1);

    logic [CNT_W-1:0] idle_cnt;
    logic             seen;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idle_cnt <= '0;
            seen     <= 1'b0;
        end else if (frame_end) begin
            seen <= 1'b0;
            if (seen || hit || idle_cnt == LIMIT_V)
                idle_cnt <= '0;
            else
                idle_cnt <= idle_cnt + 1'b1;
        end else if (hit) begin
            seen     <= 1'b1;
            idle_cnt <= '0;
        end
    end

    assign expire = !clr && frame_end && !seen && !hit && (idle_cnt == LIMIT_V);

    // R8: idle count stays below the limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LIMIT_V);

    // R9: activity earlier in the frame blocks expiry at frame close
    a_r9_seen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr && !frame_end) |=> !expire);

endmodule

// File: rtl/chirp_sequencer.sv
module chirp_sequencer
    import chirp_seq_pkg::*;
#(
    parameter int PRI_CYCLES     = 1000,
    parameter int CHIRPS_PER_SUB = 16,
    parameter int IDLE_FRAMES    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       ext_req,
    input  logic [2:0] wave_mask,
    input  logic [1:0] fixed_wave,
    input  logic       track_hit,
    output logic [1:0] wave_sel,
    output logic       chirp_pulse
);
    seq_state_e state, state_n;
    logic [1:0] cur_wave, cur_wave_n;
    logic       req_q;
    logic       back_pend, back_pend_n;
    logic       tmr_clr, tmr_run;
    logic       slot_start, slot_last, chirp_first, frame_end;
    logic       wd_clr, wd_expire;
    logic [1:0] rot_next, first_wave;
    logic       any_en, cur_en, mode_switch;
    logic       pulse_d;
    logic [1:0] wave_d;

    function automatic logic [1:0] state_mode(input seq_state_e s);
        case (s)
            ST_PASS:                  state_mode = MODE_PASS;
            ST_SCAN:                  state_mode = MODE_SCAN;
            ST_DBG_FIRE, ST_DBG_HOLD: state_mode = MODE_DEBUG;
            default:                  state_mode = MODE_TRACK;
        endcase
    endfunction

    function automatic seq_state_e entry_state(input logic [1:0] m);
        case (m)
            MODE_PASS:  entry_state = ST_PASS;
            MODE_SCAN:  entry_state = ST_SCAN;
            MODE_DEBUG: entry_state = ST_DBG_FIRE;
            default:    entry_state = ST_DWELL;
        endcase
    endfunction

    assign any_en      = |wave_mask;
    assign cur_en      = wave_mask[cur_wave];
    assign mode_switch = (mode_sel != state_mode(state));
    assign wd_clr      = (state != ST_DWELL) || mode_switch;

    chirp_seq_slot_timer #(
        .PRI_CYCLES     (PRI_CYCLES),
        .CHIRPS_PER_SUB (CHIRPS_PER_SUB)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (tmr_clr),
        .run         (tmr_run),
        .slot_start  (slot_start),
        .slot_last   (slot_last),
        .chirp_first (chirp_first),
        .frame_end   (frame_end)
    );

    chirp_seq_wave_rotor u_rot_next (
        .from_wave (cur_wave),
        .wave_mask (wave_mask),
        .next_wave (rot_next)
    );

    // starting from LONG, the successor search lands on the first enabled code
    chirp_seq_wave_rotor u_rot_first (
        .from_wave (WAVE_LONG),
        .wave_mask (wave_mask),
        .next_wave (first_wave)
    );

    chirp_seq_idle_watchdog #(
        .IDLE_FRAMES (IDLE_FRAMES)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wd_clr),
        .frame_end (frame_end),
        .hit       (track_hit),
        .expire    (wd_expire)
    );

    // next-state logic
    always_comb begin
        state_n     = state;
        cur_wave_n  = cur_wave;
        back_pend_n = back_pend;
        tmr_clr     = 1'b0;
        tmr_run     = 1'b1;
        if (mode_switch) begin
            state_n     = entry_state(mode_sel);
            tmr_clr     = 1'b1;
            back_pend_n = 1'b0;
            cur_wave_n  = first_wave;
        end else begin
            unique case (state)
                ST_PASS, ST_DBG_HOLD: begin
                    tmr_clr = 1'b1;
                end
                ST_DBG_FIRE: begin
                    state_n = ST_DBG_HOLD;
                    tmr_clr = 1'b1;
                end
                ST_SCAN, ST_FALLBACK: begin
                    if (slot_start && chirp_first && any_en && !cur_en) begin
                        cur_wave_n = rot_next;   // skip costs no slot
                        tmr_run    = 1'b0;
                    end else if (frame_end) begin
                        cur_wave_n = rot_next;
                    end
                    if (state == ST_FALLBACK) begin
                        if (track_hit)
                            back_pend_n = 1'b1;
                        if (slot_last && (back_pend || track_hit)) begin
                            state_n     = ST_DWELL;
                            tmr_clr     = 1'b1;
                            back_pend_n = 1'b0;
                        end
                    end
                end
                ST_DWELL: begin
                    if (wd_expire) begin
                        state_n    = ST_FALLBACK;
                        tmr_clr    = 1'b1;
                        cur_wave_n = first_wave;
                    end
                end
                default: begin
                    state_n = ST_PASS;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PASS;
            cur_wave  <= WAVE_SHORT;
            req_q     <= 1'b0;
            back_pend <= 1'b0;
        end else begin
            state     <= state_n;
            cur_wave  <= cur_wave_n;
            req_q     <= ext_req;
            back_pend <= back_pend_n;
        end
    end

    // output decode
    always_comb begin
        pulse_d = 1'b0;
        wave_d  = fixed_wave;
        unique case (state)
            ST_PASS:     pulse_d = ext_req && !req_q;
            ST_DBG_FIRE: pulse_d = 1'b1;
            ST_DBG_HOLD: pulse_d = 1'b0;
            ST_SCAN, ST_FALLBACK: begin
                pulse_d = slot_start && cur_en;
                wave_d  = cur_wave;
            end
            ST_DWELL:    pulse_d = slot_start;
            default:     pulse_d = 1'b0;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chirp_pulse <= 1'b0;
            wave_sel    <= WAVE_SHORT;
        end else begin
            chirp_pulse <= pulse_d;
            wave_sel    <= wave_d;
        end
    end

    // R2: strobe lasts one cycle unless a mode change starts a new chirp
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_d && !mode_switch) |=> !pulse_d);

    // R3: pass-through chirps only while the request is high
    a_r3_pass_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && pulse_d) |-> ext_req);

    // R4: scan waveform changes only together with a chirp start
    a_r4_wave_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && $past(state) == ST_SCAN
         && $past(wave_mask) == wave_mask && wave_d != $past(wave_d)) |-> pulse_d);

    // R5: empty mask silences scanning
    a_r5_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SCAN || state == ST_FALLBACK) && !any_en) |-> !pulse_d);

    // R6: nothing after the single debug chirp
    a_r6_debug_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DBG_HOLD) |-> !pulse_d);

    // R8: fallback entered only through watchdog expiry
    a_r8_fallback_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FALLBACK && $past(state) == ST_DWELL) |-> $past(wd_expire));

    // R10: return to dwell starts on a fresh slot
    a_r10_return_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DWELL && $past(state) == ST_FALLBACK) |-> slot_start);

endmodule

// File: tb/chirp_sequencer_test.sv
module chirp_sequencer_test;
    localparam int PRI = 8;
    localparam int NCH = 2;
    localparam int IDL = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       ext_req;
    logic [2:0] wave_mask;
    logic [1:0] fixed_wave;
    logic       track_hit;
    logic [1:0] wave_sel;
    logic       chirp_pulse;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int pc = 0;
    int pt [0:63];
    int pw [0:63];
    bit done = 0;

    always #5 clk = ~clk;

    chirp_sequencer #(
        .PRI_CYCLES     (PRI),
        .CHIRPS_PER_SUB (NCH),
        .IDLE_FRAMES    (IDL)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .ext_req     (ext_req),
        .wave_mask   (wave_mask),
        .fixed_wave  (fixed_wave),
        .track_hit   (track_hit),
        .wave_sel    (wave_sel),
        .chirp_pulse (chirp_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
        cyc++;
        if (chirp_pulse && pc < 64) begin
            pt[pc] = cyc;
            pw[pc] = int'(wave_sel);
            pc++;
        end
    endtask

    task automatic go_idle();
        mode_sel = 2'b00;
        repeat (3) tick();
        pc = 0;
    endtask

    task automatic wait_pulses(input int n, input int limit);
        for (int i = 0; i < limit && pc < n; i++) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_sel = 2'b00; ext_req = 1'b0;
        wave_mask = 3'b111; fixed_wave = 2'b01; track_hit = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pulse in reset", int'(chirp_pulse), 0);
        chk("R1 wave in reset", int'(wave_sel), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 pulse after reset", int'(chirp_pulse), 0);
        tick();
        chk("R1 wave follows fixed", int'(wave_sel), 1);
        chk("R1 no pulses", pc, 0);
    endtask

    task automatic t_pass();
        go_idle();
        ext_req = 1'b1;
        repeat (6) tick();
        chk("R3 held request one pulse", pc, 1);
        ext_req = 1'b0;
        repeat (3) tick();
        ext_req = 1'b1;
        tick();
        ext_req = 1'b0;
        repeat (4) tick();
        chk("R3 two edges two pulses", pc, 2);
        chk("R3 pass wave", pw[0], 1);
        chk("R2 pulse width", int'(chirp_pulse), 0);
    endtask

    task automatic t_scan_all();
        int t0;
        int ew [0:6];
        ew = '{0, 0, 1, 1, 2, 2, 0};
        go_idle();
        wave_mask = 3'b111;
        mode_sel = 2'b01;
        t0 = cyc;
        repeat (60) tick();
        chk("R11 entry latency", pt[0] - t0, 2);
        for (int i = 0; i < 7; i++) chk("R4 scan order", pw[i], ew[i]);
        for (int i = 1; i < 7; i++) chk("R2 spacing", pt[i] - pt[i-1], PRI);
        mode_sel = 2'b00;
        pc = 0;
        repeat (30) tick();
        chk("R11 scan stops on mode change", pc, 0);
    endtask

    task automatic t_scan_masked();
        int ew [0:6];
        ew = '{0, 0, 2, 2, 0, 0, 2};
        go_idle();
        wave_mask = 3'b101;
        mode_sel = 2'b01;
        repeat (60) tick();
        for (int i = 0; i < 7; i++) chk("R5 masked order", pw[i], ew[i]);
        chk("R5 no lost slot", pt[2] - pt[1], PRI);
        chk("R5 wrap spacing", pt[4] - pt[3], PRI);
        go_idle();
        wave_mask = 3'b000;
        mode_sel = 2'b01;
        repeat (40) tick();
        chk("R5 empty mask silent", pc, 0);
        wave_mask = 3'b111;
    endtask

    task automatic t_debug();
        go_idle();
        fixed_wave = 2'b10;
        mode_sel = 2'b10;
        repeat (40) tick();
        chk("R6 single chirp", pc, 1);
        chk("R6 debug wave", pw[0], 2);
        mode_sel = 2'b00;
        repeat (3) tick();
        mode_sel = 2'b10;
        repeat (20) tick();
        chk("R6 re-entry chirp", pc, 2);
    endtask

    task automatic t_dwell_fallback();
        int nd;
        go_idle();
        fixed_wave = 2'b10;
        wave_mask = 3'b111;
        mode_sel = 2'b11;
        repeat (110) tick();
        nd = 0;
        for (int i = 0; i < 10; i++) if (pw[i] == 2) nd++;
        chk("R7 dwell wave count", nd, 10);
        chk("R7 dwell spacing", pt[9] - pt[8], PRI);
        chk("R8 fallback wave", pw[10], 0);
        chk("R8 fallback spacing", pt[10] - pt[9], PRI);
        chk("R8 fallback rotation", pw[12], 1);
    endtask

    task automatic t_late_hit_and_return();
        int nd;
        go_idle();
        mode_sel = 2'b11;
        wait_pulses(10, 200);
        repeat (6) tick();
        track_hit = 1'b1;
        tick();
        track_hit = 1'b0;
        wait_pulses(21, 200);
        nd = 0;
        for (int i = 0; i < 20; i++) if (pw[i] == 2) nd++;
        chk("R9 hit in last frame cycle keeps dwell", nd, 20);
        chk("R9 fallback after fresh idle run", pw[20], 0);
        repeat (2) tick();
        track_hit = 1'b1;
        tick();
        track_hit = 1'b0;
        wait_pulses(23, 60);
        chk("R10 back to dwell wave", pw[21], 2);
        chk("R10 return spacing", pt[21] - pt[20], PRI);
        chk("R10 stays in dwell", pw[22], 2);
        mode_sel = 2'b00;
    endtask

    initial begin
        t_reset();
        t_pass();
        t_scan_all();
        t_scan_masked();
        t_debug();
        t_dwell_fallback();
        t_late_hit_and_return();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule